// File: doc/BRIEF.md
# LIN Transmit Readback Bit-Error Monitor

This block watches a LIN bus while the master is driving it. It receives a tick at eight times the bit rate and compares the level the master sends with the level it reads back from the bus. The comparison happens once per bit time, in the middle of the bit, so that delay on the line does not count as an error. A frame begins with a start pulse from the frame sequencer. The monitor first covers the break field, which is 13 dominant bit times and one recessive delimiter bit. It then covers the transmitted bytes one after another. Each byte is 10 bit times long, counting the start and stop bits.

When the readback differs from the sent level, the frame is aborted. The block raises a one-cycle error pulse, stops monitoring and returns to idle, ready for the next break. At the end of every byte it raises a byte-done pulse. At the end of the byte that the sequencer marked as the last one, it reports the next mode. That mode is response reception when response bytes are still pending, and idle otherwise. The bus line is never compared while the block is receiving a response.

Top module: `lin_readback_mon`

## Requirements
- R1: While a break field or a byte is being monitored, TX and RX are compared only on the tick at phase 3 of the eight ticks in each bit (the fourth tick of the bit, with phases counted 0 to 7 from the start pulse). A mismatch on any other tick has no effect.
- R2: A pulse on `brk_start_i` starts monitoring of a 14-bit break field, with the phase reset to 0. The pulse is accepted in idle mode and in receive mode.
- R3: A mismatch at a sample point makes `bit_err_o` high for exactly one cycle, on the cycle after the clock edge of that tick. Monitoring then stops and the block returns to idle. For the rest of that frame, no further byte-done or next-mode pulse appears.
- R4: When the break field ends, monitoring continues directly with bytes of 10 bit times each. The bit counter is reloaded at the start of each byte. `byte_done_o` pulses for one cycle after the final tick of the 10th bit of each byte.
- R5: If `last_byte_i` is high when a byte completes, `next_vld_o` pulses together with `byte_done_o`. `next_rx_o` is 1 when `rx_pending_i` is non-zero, and the block then enters receive mode; otherwise `next_rx_o` is 0 and the block enters idle. `next_rx_o` is 0 whenever `next_vld_o` is 0.
- R6: If `last_byte_i` is low when a byte completes, monitoring goes on with the next byte and no next-mode pulse is issued.
- R7: In idle and receive modes, ticks and TX/RX mismatches produce no error, byte-done or next-mode pulse.
- R8: After synchronous reset, all four outputs are low and the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Oversampling tick, 8 per bit time |
| brk_start_i | input | 1 | Start of a frame: begins break-field monitoring |
| tx_i | input | 1 | Level the master drives onto the bus |
| rx_i | input | 1 | Level read back from the bus |
| last_byte_i | input | 1 | The byte being sent is the last one transmitted by the master |
| rx_pending_i | input | PEND_W | Number of response bytes expected from the slave |
| bit_err_o | output | 1 | One-cycle pulse: readback mismatch, frame aborted |
| byte_done_o | output | 1 | One-cycle pulse: a byte has been fully checked |
| next_vld_o | output | 1 | One-cycle pulse: next mode decision is valid |
| next_rx_o | output | 1 | Next mode is response reception (1) or idle (0) |

## Verification
The assertions check on every cycle that an error is a single pulse and only comes from a monitoring mode. They also check that an error never coincides with a byte-done pulse, that a next-mode pulse only comes with a byte-done pulse, and that the bit counter stays within a byte's range during data. Only the bench scenarios can show that the error lands on the exact bit and phase where the mismatch was injected. The same holds for the correct number of byte-done pulses before an abort, for the idle-or-receive choice that follows from the pending count, and for the silence on the outputs in idle and receive modes. The bench runs a mismatch on every bit of a three-byte frame and on every phase of one bit.

// File: rtl/lin_bem_pkg.sv
package lin_bem_pkg;

    typedef enum logic [1:0] {
        MODE_IDLE  = 2'd0,
        MODE_BREAK = 2'd1,
        MODE_DATA  = 2'd2,
        MODE_RECV  = 2'd3
    } bem_mode_e;

    typedef struct packed {
        logic bit_err;
        logic byte_done;
        logic next_vld;
        logic next_rx;
    } bem_out_t;

    localparam bem_out_t BEM_OUT_NONE = '{bit_err: 1'b0, byte_done: 1'b0,
                                          next_vld: 1'b0, next_rx: 1'b0};

    function automatic logic is_driving(bem_mode_e m);
        return (m == MODE_BREAK) || (m == MODE_DATA);
    endfunction

    function automatic logic can_start(bem_mode_e m);
        return (m == MODE_IDLE) || (m == MODE_RECV);
    endfunction

    function automatic int unsigned max_u(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/lin_bem_phase.sv
module lin_bem_phase #(
    parameter int unsigned OS  = 8,
    parameter int unsigned SMP = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic tick,
    output logic smp_stb,
    output logic end_stb
);
    localparam int unsigned PH_W = (OS > 1) ? $clog2(OS) : 1;
    localparam logic [PH_W-1:0] PH_SMP  = PH_W'(SMP);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(OS - 1);

    logic [PH_W-1:0] ph_q;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            ph_q <= '0;
        end else if (tick) begin
            ph_q <= (ph_q == PH_LAST) ? '0 : ph_q + 1'b1;
        end
    end

    assign smp_stb = tick && (ph_q == PH_SMP);
    assign end_stb = tick && (ph_q == PH_LAST);

endmodule

// File: rtl/lin_bem_bitcnt.sv
module lin_bem_bitcnt #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic [CNT_W-1:0] cnt,
    output logic             final_bit
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign cnt       = cnt_q;
    assign final_bit = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/lin_readback_mon.sv
module lin_readback_mon
    import lin_bem_pkg::*;
#(
    parameter int unsigned OS        = 8,
    parameter int unsigned SMP       = 3,
    parameter int unsigned BRK_BITS  = 14,
    parameter int unsigned BYTE_BITS = 10,
    parameter int unsigned PEND_W    = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic              brk_start_i,
    input  logic              tx_i,
    input  logic              rx_i,
    input  logic              last_byte_i,
    input  logic [PEND_W-1:0] rx_pending_i,
    output logic              bit_err_o,
    output logic              byte_done_o,
    output logic              next_vld_o,
    output logic              next_rx_o
);
    localparam int unsigned CNT_MAX = max_u(BRK_BITS, BYTE_BITS);
    localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] LD_BRK  = CNT_W'(BRK_BITS);
    localparam logic [CNT_W-1:0] LD_BYTE = CNT_W'(BYTE_BITS);

    bem_mode_e        state_q, state_d;
    bem_out_t         out_q, out_d;
    logic             smp_stb, end_stb, ph_restart;
    logic             cnt_load, cnt_dec, final_bit;
    logic [CNT_W-1:0] cnt_ld_val, cnt_val;
    logic             monitoring, mismatch, field_end;

    lin_bem_phase #(.OS(OS), .SMP(SMP)) u_phase (
        .clk     (clk),
        .rst     (rst),
        .restart (ph_restart),
        .tick    (tick_i),
        .smp_stb (smp_stb),
        .end_stb (end_stb)
    );

    lin_bem_bitcnt #(.CNT_W(CNT_W)) u_bitcnt (
        .clk       (clk),
        .rst       (rst),
        .load      (cnt_load),
        .load_val  (cnt_ld_val),
        .dec       (cnt_dec),
        .cnt       (cnt_val),
        .final_bit (final_bit)
    );

    assign monitoring = is_driving(state_q);
    assign mismatch   = monitoring && smp_stb && (tx_i != rx_i);
    assign field_end  = monitoring && end_stb && final_bit;

    always_comb begin
        state_d    = state_q;
        out_d      = BEM_OUT_NONE;
        ph_restart = 1'b0;
        cnt_load   = 1'b0;
        cnt_ld_val = LD_BYTE;
        cnt_dec    = 1'b0;
        if (brk_start_i && can_start(state_q)) begin
            state_d    = MODE_BREAK;
            ph_restart = 1'b1;
            cnt_load   = 1'b1;
            cnt_ld_val = LD_BRK;
        end else if (mismatch) begin
            state_d       = MODE_IDLE;
            out_d.bit_err = 1'b1;
        end else if (field_end) begin
            if (state_q == MODE_BREAK) begin
                state_d  = MODE_DATA;
                cnt_load = 1'b1;
            end else begin
                out_d.byte_done = 1'b1;
                if (last_byte_i) begin
                    out_d.next_vld = 1'b1;
                    out_d.next_rx  = (rx_pending_i != '0);
                    state_d        = (rx_pending_i != '0) ? MODE_RECV : MODE_IDLE;
                end else begin
                    cnt_load = 1'b1;
                end
            end
        end else if (monitoring && end_stb) begin
            cnt_dec = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= MODE_IDLE;
            out_q   <= BEM_OUT_NONE;
        end else begin
            state_q <= state_d;
            out_q   <= out_d;
        end
    end

    assign bit_err_o   = out_q.bit_err;
    assign byte_done_o = out_q.byte_done;
    assign next_vld_o  = out_q.next_vld;
    assign next_rx_o   = out_q.next_rx;

    AST_ERR_PULSE: assert property (@(posedge clk) disable iff (rst)
        bit_err_o |=> !bit_err_o); // R3

    AST_ERR_NOT_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        bit_err_o |-> !byte_done_o); // R3

    AST_ERR_FROM_DRIVING: assert property (@(posedge clk) disable iff (rst)
        bit_err_o |-> ($past(state_q) == MODE_BREAK || $past(state_q) == MODE_DATA)); // R7

    AST_BITCNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        (state_q == MODE_DATA) |-> (cnt_val != '0 && cnt_val <= LD_BYTE)); // R4

    AST_NEXT_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        next_vld_o |-> byte_done_o); // R5

    AST_RX_NEEDS_VLD: assert property (@(posedge clk) disable iff (rst)
        next_rx_o |-> next_vld_o); // R5

    AST_RECV_AFTER_RX: assert property (@(posedge clk) disable iff (rst)
        next_rx_o |-> (state_q == MODE_RECV)); // R5

endmodule

// File: tb/tb_lin_readback_mon.sv
module tb_lin_readback_mon;
    localparam int BRK = 14;
    localparam int BYT = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_i = 1'b0, brk_start_i = 1'b0, tx_i = 1'b1, rx_i = 1'b1, last_byte_i = 1'b0;
    logic [3:0] rx_pending_i = '0;
    logic       bit_err_o, byte_done_o, next_vld_o, next_rx_o;

    int checks = 0, errors = 0, cyc = 0;
    int n_err = 0, n_done = 0, n_vld = 0, n_rx = 0;

    always #5 clk = ~clk;

    lin_readback_mon dut (
        .clk(clk), .rst(rst), .tick_i(tick_i), .brk_start_i(brk_start_i),
        .tx_i(tx_i), .rx_i(rx_i), .last_byte_i(last_byte_i), .rx_pending_i(rx_pending_i),
        .bit_err_o(bit_err_o), .byte_done_o(byte_done_o),
        .next_vld_o(next_vld_o), .next_rx_o(next_rx_o)
    );

    always @(negedge clk) begin
        if (!rst) begin
            n_err  += int'(bit_err_o);
            n_done += int'(byte_done_o);
            n_vld  += int'(next_vld_o);
            n_rx   += int'(next_rx_o);
        end
    end

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            errors++;
            $display("FAIL watchdog: actual run length %0d, expected completion earlier", cyc);
            summary();
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic tx_level(int g, int nb);
        int k;
        if (g < BRK - 1) return 1'b0;
        if (g == BRK - 1) return 1'b1;
        k = (g - BRK) % BYT;
        if (k == 0) return 1'b0;
        if (k == BYT - 1) return 1'b1;
        return 1'(((((g - BRK) / BYT) * 73 + 53 + nb) >> (k - 1)) & 1);
    endfunction

    // Runs one frame of nb bytes; ebit < 0 means no injected mismatch.
    task automatic run_frame(int nb, int pend, int ebit, int eph);
        int b_err, b_done, b_vld, b_rx, total;
        int exp_err, exp_done, exp_vld, exp_rx;
        b_err = n_err; b_done = n_done; b_vld = n_vld; b_rx = n_rx;
        total = BRK + BYT * nb;
        rx_pending_i = 4'(pend);
        brk_start_i = 1'b1;
        @(posedge clk); #1;
        brk_start_i = 1'b0;
        for (int g = 0; g < total; g++) begin
            for (int p = 0; p < 8; p++) begin
                tx_i        = tx_level(g, nb);
                rx_i        = (g == ebit && p == eph) ? ~tx_level(g, nb) : tx_level(g, nb);
                last_byte_i = (g >= BRK + BYT * (nb - 1));
                tick_i      = 1'b1;
                @(posedge clk); #1;
            end
        end
        tick_i = 1'b0; last_byte_i = 1'b0; rx_i = tx_i;
        repeat (2) @(posedge clk);
        #1;
        if (ebit >= 0 && eph == 3) begin
            exp_err  = 1;
            exp_done = (ebit < BRK) ? 0 : (ebit - BRK) / BYT;
            exp_vld  = 0;
            exp_rx   = 0;
        end else begin
            exp_err  = 0;
            exp_done = nb;
            exp_vld  = 1;
            exp_rx   = (pend != 0) ? 1 : 0;
        end
        chk((ebit >= 0) ? "R1/R3 error count" : "R2 no error on clean frame", n_err - b_err, exp_err);
        chk((ebit >= 0) ? "R3 byte_done before abort" : "R4/R6 byte_done count", n_done - b_done, exp_done);
        chk("R5 next_vld count", n_vld - b_vld, exp_vld);
        chk("R5 next_rx count", n_rx - b_rx, exp_rx);
    endtask

    // Drives mismatching ticks with no frame active.
    task automatic quiet_window(string req);
        int b_err, b_done, b_vld;
        b_err = n_err; b_done = n_done; b_vld = n_vld;
        for (int i = 0; i < 24; i++) begin
            tx_i = 1'(i & 1); rx_i = ~tx_i; tick_i = 1'b1; last_byte_i = 1'b1;
            @(posedge clk); #1;
        end
        tick_i = 1'b0; rx_i = tx_i; last_byte_i = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        chk(req, n_err - b_err, 0);
        chk(req, n_done - b_done, 0);
        chk(req, n_vld - b_vld, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R8 bit_err after reset", int'(bit_err_o), 0);
        chk("R8 byte_done after reset", int'(byte_done_o), 0);
        chk("R8 next_vld after reset", int'(next_vld_o), 0);
        chk("R8 next_rx after reset", int'(next_rx_o), 0);
        rst = 1'b0;
        @(posedge clk); #1;
        quiet_window("R7 idle ignores mismatches");

        for (int nb = 1; nb <= 3; nb++) begin
            for (int pend = 0; pend <= 1; pend++) begin
                run_frame(nb, pend * (nb + 2), -1, 0);
                if (pend != 0) quiet_window("R7 receive mode ignores mismatches");
                else           quiet_window("R7 idle after last byte ignores mismatches");
            end
        end

        for (int e = 0; e < BRK + 3 * BYT; e++) begin
            run_frame(3, 2, e, 3);
        end

        for (int p = 0; p < 8; p++) begin
            run_frame(2, 1, 20, p);
        end

        summary();
        $finish;
    end

endmodule